// File: doc/BRIEF.md
# Bit-Serial XOR Encryption Back End

This block turns a byte-wide keystream and byte-wide plaintext into one encrypted bit per clock. Plaintext bytes are written into an eight-entry first-in first-out buffer. Whenever a keystream byte is offered and the buffer holds at least one byte, the block takes both bytes in the same cycle. It loads each into its own parallel-to-serial shift register. The two registers then shift together, most significant bit first, and each output bit is the XOR of the two bits leaving the registers.

A valid flag marks the eight output bits of each byte. An end-of-conversion pulse marks the last of them. Because XOR with the same keystream undoes itself, feeding ciphertext bytes through the same path with the same keystream gives back the plaintext. The block does not generate the keystream.

The controller has two named states:
- `CTL_IDLE` waits for a keystream handshake.
- `CTL_SHIFT` streams the eight bits.

It has two named transitions:
- *accept* goes from `CTL_IDLE` to `CTL_SHIFT` on `ks_valid && ks_ready`.
- *finish* goes from `CTL_SHIFT` to `CTL_IDLE` on the eighth bit, when the bit counter equals 7.

Top module: `xor_bit_serializer`

## Requirements
- R1: After reset, `ser_valid`, `ser_eoc`, `ser_bit`, `pt_full` and `ks_ready` are all low.
- R2: `ks_ready` is high only when the controller is idle and the plaintext buffer holds at least one byte. It is low while a byte is being shifted out and while the buffer is empty.
- R3: A clock edge with `ks_valid` and `ks_ready` both high consumes one keystream byte and the oldest buffered plaintext byte. `ser_valid` is then high for exactly 8 consecutive clocks, starting in the cycle after that edge.
- R4: In the k-th valid cycle (k = 0..7), `ser_bit` equals plaintext bit 7-k XOR keystream bit 7-k, so the most significant bit comes first. `ser_bit` is low whenever `ser_valid` is low.
- R5: `ser_eoc` is a one-clock pulse that is high together with the eighth valid bit of each byte, and at no other time.
- R6: Plaintext bytes leave the buffer in the order they were written. `pt_full` is high exactly when all 8 entries are occupied.
- R7: A write presented while `pt_full` is high is ignored. The buffer's contents do not change, and the ignored byte never appears in the output.
- R8: Feeding the produced ciphertext byte back in with the same keystream byte reproduces the original plaintext byte.
- R9: A plaintext write during the shifting of a byte is accepted and is served by a later keystream byte.
- R10: `ks_valid` presented while `ks_ready` is low consumes nothing and produces no output bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pt_wr_en | input | 1 | Plaintext byte write strobe |
| pt_wr_data | input | 8 | Plaintext (or ciphertext) byte to buffer |
| pt_full | output | 1 | High when all 8 buffer entries are occupied |
| ks_valid | input | 1 | Keystream byte is offered |
| ks_data | input | 8 | Keystream byte |
| ks_ready | output | 1 | Block will take the offered keystream byte at this edge |
| ser_bit | output | 1 | Encrypted serial bit |
| ser_valid | output | 1 | `ser_bit` carries data |
| ser_eoc | output | 1 | Last bit of the current byte |

## Verification
The hardest condition to reach from the ports is a write that arrives while the buffer is already full. It can only occur after eight writes with no keystream offered. The stimulus therefore fills the buffer, offers a ninth distinctive byte, and then drains all eight entries with known keystream bytes. After the drain it confirms that the buffer reports empty through `ks_ready`, so the ninth byte was never stored. A second hard case is a write that lands mid-byte while the controller is shifting. The stimulus injects a write on the fourth bit, and a later keystream byte must then pair with that written byte.

// File: rtl/xorser_pkg.sv
package xorser_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [0:0] {
        CTL_IDLE  = 1'b0,
        CTL_SHIFT = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/xorser_fifo.sv
module xorser_fifo #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_wr, do_rd;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_wr   = wr_en && !full;
    assign do_rd   = rd_en && !empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            unique case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R7: a write against a full buffer without a pop leaves it full and unchanged
    a_r7_full_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr_en && !rd_en) |=> (full && $stable(wr_ptr)));

    // R6: the buffer is never popped while empty
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);

endmodule

// File: rtl/xorser_piso.sv
module xorser_piso #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_data,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     sr <= '0;
        else if (load)  sr <= load_data;
        else if (shift) sr <= {sr[W-2:0], 1'b0};
    end

    assign msb = sr[W-1];

endmodule

// File: rtl/xorser_ctrl.sv
module xorser_ctrl
    import xorser_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    input  logic ks_valid,
    output logic ks_ready,
    output logic load,
    output logic shift,
    output logic out_valid,
    output logic out_eoc
);
    localparam int unsigned CNTW = $clog2(W);
    localparam logic [CNTW-1:0] LAST_BIT = CNTW'(W - 1);

    ctl_state_e    state, state_nx;
    logic [CNTW-1:0] bit_cnt;
    logic          accept, finish;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= CTL_IDLE;
            bit_cnt <= '0;
        end else begin
            state <= state_nx;
            if (accept)     bit_cnt <= '0;
            else if (shift) bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            CTL_IDLE:  if (accept) state_nx = CTL_SHIFT;
            CTL_SHIFT: if (finish) state_nx = CTL_IDLE;
            default:   state_nx = CTL_IDLE;
        endcase
    end

    always_comb begin
        ks_ready  = 1'b0;
        shift     = 1'b0;
        out_valid = 1'b0;
        out_eoc   = 1'b0;
        unique case (state)
            CTL_IDLE: ks_ready = !fifo_empty;
            CTL_SHIFT: begin
                shift     = 1'b1;
                out_valid = 1'b1;
                out_eoc   = (bit_cnt == LAST_BIT);
            end
            default: ;
        endcase
    end

    assign accept = ks_ready && ks_valid;
    assign load   = accept;
    assign finish = out_eoc;

    // R2: ready only with a buffered byte and no byte in flight
    a_r2_ready_gated: assert property (@(posedge clk) disable iff (!rst_n)
        ks_ready |-> (!fifo_empty && !out_valid));

    // R3: a handshake starts a burst at the next clock
    a_r3_burst_starts: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_valid && ks_ready) |=> out_valid);

    // R3: a burst runs on until its end-of-conversion bit
    a_r3_burst_continues: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_eoc) |=> out_valid);

    // R5: end-of-conversion is a single pulse and closes the burst
    a_r5_eoc_single: assert property (@(posedge clk) disable iff (!rst_n)
        out_eoc |=> (!out_valid && !out_eoc));

    // R5: end-of-conversion only rides on a valid bit
    a_r5_eoc_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        out_eoc |-> out_valid);

endmodule

// File: rtl/xor_bit_serializer.sv
module xor_bit_serializer
    import xorser_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pt_wr_en,
    input  logic [BYTE_W-1:0] pt_wr_data,
    output logic              pt_full,
    input  logic              ks_valid,
    input  logic [BYTE_W-1:0] ks_data,
    output logic              ks_ready,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic              ser_eoc
);
    logic [BYTE_W-1:0] fifo_q;
    logic fifo_empty, load, shift, pt_msb, ks_msb;

    xorser_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(pt_wr_en), .wr_data(pt_wr_data),
        .rd_en(load), .rd_data(fifo_q),
        .full(pt_full), .empty(fifo_empty)
    );

    xorser_ctrl #(.W(BYTE_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(fifo_empty), .ks_valid(ks_valid), .ks_ready(ks_ready),
        .load(load), .shift(shift),
        .out_valid(ser_valid), .out_eoc(ser_eoc)
    );

    xorser_piso #(.W(BYTE_W)) u_pt_sr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(fifo_q),
        .shift(shift), .msb(pt_msb)
    );

    xorser_piso #(.W(BYTE_W)) u_ks_sr (
        .clk(clk), .rst_n(rst_n), .load(load), .load_data(ks_data),
        .shift(shift), .msb(ks_msb)
    );

    assign ser_bit = ser_valid & (pt_msb ^ ks_msb);

    // R4: the serial bit is quiet outside a burst
    a_r4_bit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> !ser_bit);

    // R10: no keystream is taken while a byte is in flight
    a_r10_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> !ks_ready);

endmodule

// File: tb/sim_xor_bit_serializer.sv
module sim_xor_bit_serializer;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pt_wr_en = 1'b0;
    logic [7:0] pt_wr_data = '0;
    logic pt_full;
    logic ks_valid = 1'b0;
    logic [7:0] ks_data = '0;
    logic ks_ready, ser_bit, ser_valid, ser_eoc;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xor_bit_serializer u0 (
        .clk(clk), .rst_n(rst_n),
        .pt_wr_en(pt_wr_en), .pt_wr_data(pt_wr_data), .pt_full(pt_full),
        .ks_valid(ks_valid), .ks_data(ks_data), .ks_ready(ks_ready),
        .ser_bit(ser_bit), .ser_valid(ser_valid), .ser_eoc(ser_eoc)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_pt(input logic [7:0] d);
        pt_wr_en = 1'b1; pt_wr_data = d;
        @(negedge clk);
        pt_wr_en = 1'b0;
    endtask

    // Offer a keystream byte, collect the 8 output bits and compare against pt ^ ks.
    task automatic run_byte(input logic [7:0] ks, input logic [7:0] pt,
                            input bit inj, input logic [7:0] inj_d,
                            output logic [7:0] got);
        int waited = 0;
        logic ok_valid = 1'b1;
        logic ok_eoc = 1'b1;
        while (!ks_ready && waited < 20) begin
            @(negedge clk); waited++;
        end
        check({7'b0, ks_ready}, 8'h01, "R2 ready with data");
        ks_valid = 1'b1; ks_data = ks;
        @(negedge clk);
        ks_valid = 1'b0;
        got = '0;
        for (int k = 0; k < 8; k++) begin
            if (ser_valid !== 1'b1) ok_valid = 1'b0;
            if (ser_eoc !== (k == 7)) ok_eoc = 1'b0;
            if (k == 0) check({7'b0, ks_ready}, 8'h00, "R2 ready low while shifting");
            got = {got[6:0], ser_bit};
            if (inj && k == 3) begin
                pt_wr_en = 1'b1; pt_wr_data = inj_d;
            end else pt_wr_en = 1'b0;
            @(negedge clk);
        end
        pt_wr_en = 1'b0;
        check({7'b0, ok_valid}, 8'h01, "R3 eight valid clocks");
        check({7'b0, ser_valid}, 8'h00, "R3 valid ends after 8");
        check({7'b0, ok_eoc}, 8'h01, "R5 eoc on eighth bit only");
        check(got, pt ^ ks, "R4 msb-first xor");
    endtask

    task automatic t_reset();
        check({7'b0, ser_valid}, 8'h00, "R1 valid");
        check({7'b0, ser_eoc}, 8'h00, "R1 eoc");
        check({7'b0, ser_bit}, 8'h00, "R1 bit");
        check({7'b0, pt_full}, 8'h00, "R1 full");
        check({7'b0, ks_ready}, 8'h00, "R1 ready");
    endtask

    task automatic t_basic();
        logic [7:0] g;
        write_pt(8'hA5);
        run_byte(8'h0F, 8'hA5, 1'b0, 8'h00, g);
        write_pt(8'h00);
        run_byte(8'hFF, 8'h00, 1'b0, 8'h00, g);
        write_pt(8'h81);
        run_byte(8'h81, 8'h81, 1'b0, 8'h00, g);
        check({7'b0, ks_ready}, 8'h00, "R2 ready low when empty");
    endtask

    task automatic t_ignored_ks();
        // R10: keystream offered with an empty buffer is not consumed
        logic [7:0] g;
        logic seen = 1'b0;
        ks_valid = 1'b1; ks_data = 8'h3C;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ser_valid || ks_ready) seen = 1'b1;
        end
        ks_valid = 1'b0;
        check({7'b0, seen}, 8'h00, "R10 no output without ready");
        write_pt(8'h66);
        run_byte(8'h99, 8'h66, 1'b0, 8'h00, g);
    endtask

    task automatic t_full();
        logic [7:0] g;
        for (int i = 0; i < 8; i++) begin
            if (i == 7) check({7'b0, pt_full}, 8'h00, "R6 not full at 7");
            write_pt(8'(8'h10 + i));
        end
        check({7'b0, pt_full}, 8'h01, "R6 full at 8");
        write_pt(8'hEE);
        check({7'b0, pt_full}, 8'h01, "R7 still full");
        for (int i = 0; i < 8; i++)
            run_byte(8'(8'h5A ^ i), 8'(8'h10 + i), 1'b0, 8'h00, g);
        check({7'b0, ks_ready}, 8'h00, "R7 ignored byte not stored");
        check({7'b0, pt_full}, 8'h00, "R6 full clears");
    endtask

    task automatic t_decrypt();
        logic [7:0] c, p;
        write_pt(8'h5A);
        run_byte(8'hC3, 8'h5A, 1'b0, 8'h00, c);
        check(c, 8'h99, "R8 ciphertext");
        write_pt(c);
        run_byte(8'hC3, c, 1'b0, 8'h00, p);
        check(p, 8'h5A, "R8 round trip");
    endtask

    task automatic t_mid_write();
        logic [7:0] g;
        write_pt(8'h12);
        run_byte(8'h34, 8'h12, 1'b1, 8'hB7, g);
        check({7'b0, ks_ready}, 8'h01, "R9 mid-shift write stored");
        run_byte(8'h4E, 8'hB7, 1'b0, 8'h00, g);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_ignored_ks();
        t_full();
        t_decrypt();
        t_mid_write();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule